// File: doc/BRIEF.md
# Fuse Bit Array Controller

This block holds a 1024-bit write-once bit array, arranged as 128 bytes, and the controller that reads and programs it. Every bit of a blank array is 0, and programming can only move a bit from 0 to 1. A host issues byte-wide commands through a valid/ready pair. A read returns one byte with a one-cycle strobe. A byte program ORs the write data into the stored byte. A whole-array program walks every address in ascending order and ORs the same data byte into each one.

After each release of the logic reset, the block copies the lowest eight bytes into configuration shadow registers and then raises `boot_done`. Until then it refuses all commands. The array has its own power-on clear, `por_n`, so it keeps its contents across the logic reset, the way real fuses keep theirs. Setting the top bit of the top byte locks the array: from then on, programming has no effect.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After `por_n` is asserted, every byte address reads back 0x00.
- R2: While `boot_done` is low, `cmd_ready` is low. `boot_done` rises within 16 clock cycles after `rst_n` is released and then stays high until the next reset.
- R3: When `boot_done` rises, `cfg_shadow[8*i+7:8*i]` equals stored byte i for i in 0..7. Programming done after that leaves `cfg_shadow` unchanged until the next reset.
- R4: A read (`cmd_op` = 2'b00) accepted on a clock edge makes `rd_valid` high for the following cycle, with `rd_data` equal to the stored byte at `cmd_addr`. `rd_valid` is never high except in that cycle.
- R5: A byte program (`cmd_op` = 2'b01) leaves the stored byte equal to its old value ORed with `cmd_wdata`. No bit ever returns from 1 to 0.
- R6: `prog_err` pulses for one cycle, in the cycle a byte's busy period ends, exactly when the request has a 0 where that byte already holds a 1. The remaining bits are still ORed in.
- R7: After a byte program is accepted, `cmd_ready` is low for exactly 4 cycles.
- R8: A whole-array program (`cmd_op` = 2'b10) ORs `cmd_wdata` into addresses 0 to 127 in ascending order. It keeps `cmd_ready` low for 128×4 cycles and raises one `prog_err` pulse for each byte that conflicts.
- R9: Once bit 7 of byte 127 is 1, every program command, byte or whole-array, leaves the array unchanged. Each such command takes one 4-cycle busy period and ends with a `prog_err` pulse.
- R10: Asserting `rst_n` alone does not change the array contents.
- R11: Command code 2'b11 is accepted with no effect. It gives no `rd_valid`, no busy period and no change to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on clear of the bit array |
| rst_n | input | 1 | Active-low asynchronous logic reset, released synchronously |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted on the edge where valid and ready are both high |
| cmd_op | input | 2 | 00 read, 01 program byte, 10 program all, 11 no operation |
| cmd_addr | input | 7 | Byte address |
| cmd_wdata | input | 8 | Program data |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| prog_err | output | 1 | One-cycle pulse for a program that conflicts or is locked |
| boot_done | output | 1 | Readout after reset has finished |
| cfg_shadow | output | 64 | Bytes 0..7 captured at boot, byte i in bits 8i+7..8i |

## Verification
The bench sweeps every address through blank reads, two overlapping program passes and a whole-array pass, and predicts each byte and each error pulse arithmetically. A design that wrote instead of ORing would clear bits on the second pass. A design that compared the wrong operands would miss or invent `prog_err` pulses. A walk that stopped early, or counted its busy window off by one, would show up in the busy-cycle count. The bench then applies a logic-only reset and requires the shadow to hold the programmed bytes, which fails if the array were cleared or the capture index slipped. Last, it sets the lock bit and expects both program kinds to become no-ops that still flag an error.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_PROG     = 2'b01,
    OP_PROG_ALL = 2'b10,
    OP_NOP      = 2'b11
  } fuse_op_e;

  typedef enum logic [1:0] {
    ST_BOOT = 2'b00,
    ST_IDLE = 2'b01,
    ST_BUSY = 2'b10
  } fuse_st_e;
endpackage

// File: rtl/fuse_rst_sync.sv
module fuse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fuse_bank.sv
module fuse_bank #(
  parameter int BYTES = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_byte,
  output logic          lock_bit
);
  logic [BYTES-1:0][DW-1:0] rows;

  for (genvar g = 0; g < BYTES; g++) begin : g_cell
    logic [DW-1:0] cell_q;
    logic          cell_en;

    assign cell_en = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       cell_q <= '0;
      else if (cell_en) cell_q <= cell_q | wr_data;
    end

    assign rows[g] = cell_q;
  end

  assign rd_byte  = rows[rd_addr];
  assign lock_bit = rows[BYTES-1][DW-1];
endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
  parameter int SHADOW_BYTES = 8,
  parameter int DW           = 8,
  parameter int AW           = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_en,
  input  logic [AW-1:0]              cap_idx,
  input  logic [DW-1:0]              cap_data,
  output logic [SHADOW_BYTES*DW-1:0] shadow
);
  for (genvar s = 0; s < SHADOW_BYTES; s++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic          slot_en;

    assign slot_en = cap_en && (cap_idx == AW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= cap_data;
    end

    assign shadow[s*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int BYTES        = 128,
  parameter int DW           = 8,
  parameter int AW           = 7,
  parameter int PROG_CYCLES  = 4,
  parameter int SHADOW_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [DW-1:0] rd_byte,
  input  logic          lock_bit,
  output logic          cmd_ready,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          prog_err,
  output logic          boot_done,
  output logic          cap_en,
  output logic [AW-1:0] cap_idx
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  fuse_st_e      st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          walk_q, walk_d;
  logic          blk_q, blk_d;
  logic [DW-1:0] rdd_q, rdd_d;
  logic          rdv_q, rdv_d;
  logic          err_q, err_d;
  logic          boot_q, boot_d;
  logic          last_tick;
  logic          want_walk;
  fuse_op_e      op;

  assign op        = fuse_op_e'(cmd_op);
  assign last_tick = (cnt_q == CW'(PROG_CYCLES - 1));
  assign want_walk = (op == OP_PROG_ALL) && !lock_bit;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    wd_d   = wd_q;
    walk_d = walk_q;
    blk_d  = blk_q;
    rdd_d  = rdd_q;
    rdv_d  = 1'b0;
    err_d  = 1'b0;
    boot_d = boot_q;
    cap_en = 1'b0;
    wr_en  = 1'b0;
    unique case (st_q)
      ST_BOOT: begin
        cap_en = 1'b1;
        ptr_d  = ptr_q + AW'(1);
        if (ptr_q == AW'(SHADOW_BYTES - 1)) begin
          st_d   = ST_IDLE;
          boot_d = 1'b1;
          ptr_d  = '0;
        end
      end
      ST_IDLE: begin
        if (cmd_valid) begin
          unique case (op)
            OP_READ: begin
              rdv_d = 1'b1;
              rdd_d = rd_byte;
            end
            OP_PROG, OP_PROG_ALL: begin
              st_d   = ST_BUSY;
              cnt_d  = '0;
              wd_d   = cmd_wdata;
              blk_d  = lock_bit;
              walk_d = want_walk;
              ptr_d  = want_walk ? '0 : cmd_addr;
            end
            default: ;
          endcase
        end
      end
      ST_BUSY: begin
        cnt_d = cnt_q + CW'(1);
        if (last_tick) begin
          cnt_d = '0;
          wr_en = !blk_q;
          err_d = blk_q || (|(rd_byte & ~wd_q));
          if (walk_q && (ptr_q != AW'(BYTES - 1))) ptr_d = ptr_q + AW'(1);
          else                                       st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_BOOT;
      ptr_q  <= '0;
      cnt_q  <= '0;
      wd_q   <= '0;
      walk_q <= 1'b0;
      blk_q  <= 1'b0;
      rdd_q  <= '0;
      rdv_q  <= 1'b0;
      err_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      wd_q   <= wd_d;
      walk_q <= walk_d;
      blk_q  <= blk_d;
      rdd_q  <= rdd_d;
      rdv_q  <= rdv_d;
      err_q  <= err_d;
      boot_q <= boot_d;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign rd_addr   = (st_q == ST_IDLE) ? cmd_addr : ptr_q;
  assign wr_addr   = ptr_q;
  assign wr_data   = wd_q;
  assign cap_idx   = ptr_q;
  assign rd_data   = rdd_q;
  assign rd_valid  = rdv_q;
  assign prog_err  = err_q;
  assign boot_done = boot_q;
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int BYTES        = 128,
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 4,
  parameter int SHADOW_BYTES = 8,
  localparam int AW          = $clog2(BYTES)
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [AW-1:0]              cmd_addr,
  input  logic [DW-1:0]              cmd_wdata,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_valid,
  output logic                       prog_err,
  output logic                       boot_done,
  output logic [SHADOW_BYTES*DW-1:0] cfg_shadow
);
  logic          srst_n;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_byte;
  logic          lock_bit;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          cap_en;
  logic [AW-1:0] cap_idx;

  fuse_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fuse_bank #(.BYTES(BYTES), .DW(DW), .AW(AW)) bank_i (
    .clk      (clk),
    .por_n    (por_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_byte  (rd_byte),
    .lock_bit (lock_bit)
  );

  fuse_seq #(
    .BYTES(BYTES), .DW(DW), .AW(AW),
    .PROG_CYCLES(PROG_CYCLES), .SHADOW_BYTES(SHADOW_BYTES)
  ) seq_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rd_byte   (rd_byte),
    .lock_bit  (lock_bit),
    .cmd_ready (cmd_ready),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .prog_err  (prog_err),
    .boot_done (boot_done),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx)
  );

  fuse_shadow #(.SHADOW_BYTES(SHADOW_BYTES), .DW(DW), .AW(AW)) shadow_i (
    .clk      (clk),
    .rst_n    (srst_n),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (rd_byte),
    .shadow   (cfg_shadow)
  );
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int DW           = 8,
  parameter int AW           = 7,
  parameter int SHADOW_BYTES = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [1:0]                 cmd_op,
  input logic                       rd_valid,
  input logic                       prog_err,
  input logic                       boot_done,
  input logic [SHADOW_BYTES*DW-1:0] cfg_shadow
);
  assert_no_ready_before_boot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !cmd_ready);

  assert_boot_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  assert_shadow_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> $stable(cfg_shadow));

  assert_rdvalid_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_ready && (cmd_op == 2'b00)));

  assert_err_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |-> $past(!cmd_ready));

  assert_prog_goes_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op == 2'b01)) |=> !cmd_ready);

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, prog_err}));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.DW(DW), .AW(AW), .SHADOW_BYTES(SHADOW_BYTES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .rd_valid   (rd_valid),
  .prog_err   (prog_err),
  .boot_done  (boot_done),
  .cfg_shadow (cfg_shadow)
);

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 128;

  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [6:0]  cmd_addr;
  logic [7:0]  cmd_wdata;
  logic [7:0]  rd_data;
  logic        rd_valid, prog_err, boot_done;
  logic [63:0] cfg_shadow;

  logic [7:0] model [NB];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_fuse_ctrl dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .prog_err(prog_err),
    .boot_done(boot_done), .cfg_shadow(cfg_shadow)
  );

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit locked();
    return model[NB-1][7];
  endfunction

  task automatic issue(input logic [1:0] op, input int a, input logic [7:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 7'(a); cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
    issue(2'b00, a, 8'h00);
    chk(rd_valid == 1'b1, "R4", rd_valid, 1);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic prog(input logic [1:0] op, input int a, input logic [7:0] d,
                      input int exp_busy, input int exp_errs, input string req);
    int busy = 0;
    int errs = 0;
    issue(op, a, d);
    while (!cmd_ready) begin
      busy++;
      if (prog_err) errs++;
      @(negedge clk);
    end
    if (prog_err) errs++;
    chk(busy == exp_busy, req, busy, exp_busy);
    chk(errs == exp_errs, "R6", errs, exp_errs);
  endtask

  task automatic byte_prog(input int a, input logic [7:0] d);
    int e;
    if (locked()) e = 1;
    else e = ((model[a] & ~d) != 8'h00) ? 1 : 0;
    prog(2'b01, a, d, 4, e, "R7");
    if (!locked()) model[a] = model[a] | d;
  endtask

  task automatic wait_boot();
    int n = 0;
    while (!boot_done && n < 40) begin
      chk(cmd_ready == 1'b0, "R2", cmd_ready, 0);
      n++;
      @(negedge clk);
    end
    chk(boot_done == 1'b1 && n <= 16, "R2", n, 16);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < NB; a++) rd_chk(a, model[a], req);
  endtask

  task automatic shadow_chk(input string req);
    for (int i = 0; i < 8; i++)
      chk(cfg_shadow[8*i +: 8] == model[i], req, cfg_shadow[8*i +: 8], model[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    report();
  end

  initial begin
    int nerr;
    por_n = 1'b0; rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_addr = '0; cmd_wdata = '0;
    for (int a = 0; a < NB; a++) model[a] = 8'h00;
    repeat (4) @(negedge clk);
    // R2: reset state
    chk(cmd_ready == 1'b0 && boot_done == 1'b0, "R2", {cmd_ready, boot_done}, 0);
    chk(rd_valid == 1'b0 && prog_err == 1'b0, "R4", {rd_valid, prog_err}, 0);
    por_n = 1'b1; rst_n = 1'b1;
    wait_boot();
    shadow_chk("R3");
    // R1: blank array
    read_all("R1");

    // pass 1 on a blank array: R5, no conflicts (R6)
    for (int a = 0; a < NB; a++) byte_prog(a, 8'((a * 37 + 11) & 8'h3C));
    read_all("R5");
    // pass 2 overlaps pass 1: conflicts predicted per byte (R6)
    for (int a = 0; a < NB; a++)
      byte_prog(a, (a == NB-1) ? 8'((a * 53 + 7) & 8'h7F) : 8'(a * 53 + 7));
    read_all("R5");
    chk(cfg_shadow == 64'h0, "R3", cfg_shadow, 0);

    // R11: no-op command
    issue(2'b11, 5, 8'hFF);
    chk(rd_valid == 1'b0 && cmd_ready == 1'b1, "R11", {rd_valid, cmd_ready}, 1);
    rd_chk(5, model[5], "R11");

    // R8: whole-array program
    nerr = 0;
    for (int a = 0; a < NB; a++) if ((model[a] & ~8'h41) != 8'h00) nerr++;
    prog(2'b10, 9, 8'h41, NB * 4, nerr, "R8");
    for (int a = 0; a < NB; a++) model[a] = model[a] | 8'h41;
    read_all("R8");

    // R10: logic reset keeps contents, R3 shadow reloads
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_boot();
    shadow_chk("R3");
    read_all("R10");

    // R9: lock
    byte_prog(NB-1, 8'h80);
    chk(locked() == 1'b1, "R9", locked(), 1);
    byte_prog(3, 8'hFF);
    rd_chk(3, model[3], "R9");
    prog(2'b10, 0, 8'hFF, 4, 1, "R9");
    read_all("R9");
    shadow_chk("R3");

    // R1: power-on clear gives a blank array again
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    for (int a = 0; a < NB; a++) model[a] = 8'h00;
    wait_boot();
    read_all("R1");
    byte_prog(7, 8'h5A);
    rd_chk(7, 8'h5A, "R5");

    report();
  end
endmodule